// File: doc/BRIEF.md
# Expansion Card Autoconfiguration Responder

This block is the plug-and-play identity of a 64 KB expansion card on a 16-bit bus with a 24-bit address. After bus reset the card is unconfigured. It claims the fixed configuration page and returns its identification there, one nibble per bus word. Host software reads that identification and then assigns the card a 64 KB page. It first writes the low nibble of the page number to one register. It then writes the high nibble to a second register, and that write commits the page. From the next cycle the card leaves the configuration page and its decoder matches only the assigned page. Instead of assigning a page, the host may tell the card to shut up. The card then stays silent until the next reset.

Bus cycle timing, ROM contents and the decoding of the card's own registers are left to neighbouring logic. That logic uses `card_match` and `base_addr` to decode the card's registers and reads `bus_rdata` while `cfg_hit` is high.

Top module: `acfg_responder`

## Requirements
- R1: After a reset cycle (`rst_n` low at a clock edge), `configured`, `shut_up` and `base_addr` read 0 and the staged low nibble is 0.
- R2: `cfg_hit` is 1 exactly when `bus_addr[23:16]` equals the configuration page (default 0xE8) while the card is neither configured nor shut up.
- R3: While `cfg_hit` is high and `bus_addr[15:7]` is 0, `bus_rdata[15:12]` carries a nibble of identification field `bus_addr[6:2]`: the high nibble when `bus_addr[1]` is 0 and the low nibble when it is 1. Field 0 is given true and every other field is inverted. `bus_rdata[11:0]` is 0. In every other case `bus_rdata` is 0.
- R4: The field values are as follows: 0 = 0xD1 (16-bit card, 64 KB, ROM vector valid, not free memory, not chained); 1 = product number (parameter, default 0, 42 for the combined variant); 2 = 0x00 (no space preference, shut-up supported); 4/5 = vendor 0x12/0x12 (4626); 6..9 = serial 0; 10/11 = the diagnostic vector high/low byte (default 0x1000); all other fields are 0.
- R5: A strobed write hitting offset 0x4A of the configuration page stores `bus_wnib` as the staged low nibble. Repeated writes are allowed and the last one is kept.
- R6: A strobed write hitting offset 0x48 sets `base_addr` to {`bus_wnib`, staged nibble} and sets `configured` from the next cycle.
- R7: Once configured, `cfg_hit` stays 0, `base_addr` holds, and further writes to the configuration page change nothing until reset.
- R8: `card_match` is 1 exactly when `configured` is 1 and `bus_addr[23:16]` equals `base_addr`.
- R9: A strobed write hitting offset 0x4C sets `shut_up` from the next cycle. After that, `cfg_hit`, `card_match` and `configured` stay 0 until reset, and later commits are ignored.
- R10: Reads, unstrobed writes, and writes to any other offset or outside the configuration page do not change the state.
- R11: A commit that follows reset with no staging write yields a low base nibble of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| bus_addr | input | 24 | Byte address of the current access |
| bus_strobe | input | 1 | One-cycle access qualifier |
| bus_write | input | 1 | 1 = write access |
| bus_wnib | input | 4 | Data bits D15..D12 of a write |
| bus_rdata | output | 16 | Identification read data |
| cfg_hit | output | 1 | Card claims the configuration page |
| card_match | output | 1 | Access falls in the assigned page |
| configured | output | 1 | Base address has been committed |
| shut_up | output | 1 | Card silenced until reset |
| base_addr | output | 8 | Assigned page, address bits 23..16 |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any access, and that the strobe marks at most one access per cycle, with address and data stable around the edge. The bench drives every input on the falling edge, starts each scenario with a two-cycle reset, and issues one access per cycle. Each committed-base or shut-up check therefore starts from a known unconfigured state. The stimulus includes idle cycles with a parked address, so that the decode outputs can also be compared when no access is in progress.

// File: rtl/acfg_pkg.sv
// Package: constants shared by the autoconfiguration responder.
// Assumes a 16-bit card occupying a single 64 KB page.
package acfg_pkg;

    typedef enum logic [1:0] {
        ST_UNCONF = 2'd0,
        ST_CONF   = 2'd1,
        ST_SHUT   = 2'd2
    } acfg_state_e;

    // Register offsets inside the configuration page
    localparam logic [6:0] OFF_BASE_HI = 7'h48;
    localparam logic [6:0] OFF_BASE_LO = 7'h4A;
    localparam logic [6:0] OFF_SHUTUP  = 7'h4C;

    localparam logic [15:0] VENDOR_ID   = 16'h1212;
    localparam logic [31:0] SERIAL_NO   = 32'h0000_0000;
    localparam logic [2:0]  SIZE_64K    = 3'b001;
    localparam logic [1:0]  BUS_16BIT   = 2'b11;
    localparam int          NUM_FIELDS  = 32;

    // Board-type byte: bus class, no free-memory link, ROM vector valid, no chain
    localparam logic [7:0] TYPE_BYTE = {BUS_16BIT, 1'b0, 1'b1, 1'b0, SIZE_64K};
    // Flags byte: no space preference, shut-up supported
    localparam logic [7:0] FLAG_BYTE = 8'h00;

endpackage

// File: rtl/acfg_addr_dec.sv
// Address decoder for the autoconfiguration responder.
// It claims the fixed configuration page while the card is unconfigured and not
// shut up. After a commit it matches only the assigned page.
// Assumes a page is the top PAGE_W bits of the address.
module acfg_addr_dec #(
    parameter int          ADDR_W   = 24,
    parameter int          PAGE_W   = 8,
    parameter int          REG_W    = 7,
    parameter logic [7:0]  CFG_PAGE = 8'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              configured,
    input  logic              shut_up,
    input  logic [PAGE_W-1:0] base_addr,
    output logic              cfg_hit,
    output logic              id_area,
    output logic [REG_W-1:0]  reg_off,
    output logic              card_match
);
    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;

    // Split the address into page, in-page high bits and register offset
    always_comb begin
        page    = addr[ADDR_W-1:PAGE_LSB];
        reg_off = addr[REG_W-1:0];
        id_area = (addr[PAGE_LSB-1:REG_W] == '0);
    end

    // Configuration-page claim: only while unconfigured and awake
    always_comb begin
        cfg_hit = !configured && !shut_up && (page == CFG_PAGE[PAGE_W-1:0]);
    end

    // Assigned-page match for the card's own register decoder
    always_comb begin
        card_match = configured && (page == base_addr);
    end

    AST_HIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_hit && card_match)); // R8

endmodule

// File: rtl/acfg_id_rom.sv
// Identification nibble source.
// It builds the 32-byte identification table from parameters and returns one
// nibble per word. Field 0 is given true and all other fields are inverted.
// Assumes reg_off is the byte offset inside the configuration page.
module acfg_id_rom
    import acfg_pkg::*;
#(
    parameter int          PRODUCT  = 0,
    parameter logic [15:0] DIAG_VEC = 16'h1000
) (
    input  logic [6:0] reg_off,
    output logic [3:0] nibble
);
    localparam int IDX_W = $clog2(NUM_FIELDS);

    logic [7:0] field_tbl [NUM_FIELDS];
    logic [7:0] sel_byte;

    function automatic logic [7:0] field_value(input int idx);
        logic [7:0] raw;
        case (idx)
            0:       raw = TYPE_BYTE;
            1:       raw = PRODUCT[7:0];
            2:       raw = FLAG_BYTE;
            4:       raw = VENDOR_ID[15:8];
            5:       raw = VENDOR_ID[7:0];
            6:       raw = SERIAL_NO[31:24];
            7:       raw = SERIAL_NO[23:16];
            8:       raw = SERIAL_NO[15:8];
            9:       raw = SERIAL_NO[7:0];
            10:      raw = DIAG_VEC[15:8];
            11:      raw = DIAG_VEC[7:0];
            default: raw = 8'h00;
        endcase
        return (idx == 0) ? raw : ~raw;
    endfunction

    // One table entry per field, already in bus polarity
    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        assign field_tbl[gi] = field_value(gi);
    end

    // Pick the field from offset bits 6..2 and the nibble from bit 1
    always_comb begin
        sel_byte = field_tbl[reg_off[IDX_W+1:2]];
        nibble   = reg_off[1] ? sel_byte[3:0] : sel_byte[7:4];
    end

endmodule

// File: rtl/acfg_cfg_ctrl.sv
// Configuration state keeper.
// It holds the card state (unconfigured, configured or shut up), the staged low
// nibble and the committed base page.
// Assumes wr_evt is one qualified write per cycle inside the identification area.
module acfg_cfg_ctrl
    import acfg_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [6:0]        reg_off,
    input  logic [3:0]        wnib,
    output logic              configured,
    output logic              shut_up,
    output logic [PAGE_W-1:0] base_addr
);
    localparam int HI_W = PAGE_W - 4;

    acfg_state_e state;
    logic [3:0]  staged;
    logic        awake_wr;

    // A write only counts while the card is still unconfigured
    always_comb begin
        awake_wr = wr_evt && (state == ST_UNCONF);
    end

    // Card state: commit moves to configured, shut-up command silences the card
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UNCONF;
        end else if (awake_wr) begin
            if (reg_off == OFF_BASE_HI)
                state <= ST_CONF;
            else if (reg_off == OFF_SHUTUP)
                state <= ST_SHUT;
        end
    end

    // Staged low nibble: last write to the low register wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            staged <= 4'h0;
        else if (awake_wr && reg_off == OFF_BASE_LO)
            staged <= wnib;
    end

    // Base page: high nibble from the commit write, low nibble from staging
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_addr <= '0;
        else if (awake_wr && reg_off == OFF_BASE_HI)
            base_addr <= {wnib[3:4-HI_W], staged};
    end

    // Decode state into the two flags
    always_comb begin
        configured = (state == ST_CONF);
        shut_up    = (state == ST_SHUT);
    end

    AST_CONF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured); // R7
    AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> $stable(base_addr)); // R7
    AST_SHUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        shut_up |=> (shut_up && !configured)); // R9
    AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !configured && !shut_up && reg_off == OFF_BASE_HI)
        |=> (configured && base_addr[3:0] == $past(staged))); // R6

endmodule

// File: rtl/acfg_responder.sv
// Top of the autoconfiguration responder.
// It ties the decoder, the identification table and the state keeper together
// and gates the read data.
// Assumes a 16-bit data bus whose nibble D15..D12 carries the configuration data.
module acfg_responder #(
    parameter int          ADDR_W   = 24,
    parameter int          PAGE_W   = 8,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  CFG_PAGE = 8'hE8,
    parameter int          PRODUCT  = 0,
    parameter logic [15:0] DIAG_VEC = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              bus_write,
    input  logic [3:0]        bus_wnib,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cfg_hit,
    output logic              card_match,
    output logic              configured,
    output logic              shut_up,
    output logic [PAGE_W-1:0] base_addr
);
    localparam int REG_W = 7;

    logic             id_area;
    logic [REG_W-1:0] reg_off;
    logic [3:0]       id_nib;
    logic             wr_evt;

    acfg_addr_dec #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .REG_W   (REG_W),
        .CFG_PAGE(CFG_PAGE)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .configured(configured),
        .shut_up   (shut_up),
        .base_addr (base_addr),
        .cfg_hit   (cfg_hit),
        .id_area   (id_area),
        .reg_off   (reg_off),
        .card_match(card_match)
    );

    acfg_id_rom #(
        .PRODUCT (PRODUCT),
        .DIAG_VEC(DIAG_VEC)
    ) u_rom (
        .reg_off(reg_off),
        .nibble (id_nib)
    );

    // Qualified configuration write
    always_comb begin
        wr_evt = bus_strobe && bus_write && cfg_hit && id_area;
    end

    acfg_cfg_ctrl #(
        .PAGE_W(PAGE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .reg_off   (reg_off),
        .wnib      (bus_wnib),
        .configured(configured),
        .shut_up   (shut_up),
        .base_addr (base_addr)
    );

    // Identification data: nibble in the top of the word, silent otherwise
    always_comb begin
        bus_rdata = '0;
        if (cfg_hit && id_area)
            bus_rdata[DATA_W-1:DATA_W-4] = id_nib;
    end

    AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        shut_up |-> (!cfg_hit && !card_match)); // R9

endmodule

// File: tb/acfg_responder_test.sv
// Bench: behavioural reference model compared against every output on every cycle.
module acfg_responder_test;
    localparam int PROD = 42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_strobe = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_wnib = '0;
    logic [15:0] bus_rdata;
    logic        cfg_hit, card_match, configured, shut_up;
    logic [7:0]  base_addr;

    int vectors = 0;
    int miscompares = 0;

    bit         m_conf, m_shut;
    logic [7:0] m_base;
    logic [3:0] m_stage;

    always #10 clk = ~clk;

    acfg_responder #(.PRODUCT(PROD)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .bus_write(bus_write), .bus_wnib(bus_wnib), .bus_rdata(bus_rdata),
        .cfg_hit(cfg_hit), .card_match(card_match), .configured(configured),
        .shut_up(shut_up), .base_addr(base_addr)
    );

    function automatic logic [7:0] ref_field(input int i);
        case (i)
            0:  return 8'hD1;
            1:  return PROD[7:0];
            4:  return 8'h12;
            5:  return 8'h12;
            10: return 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(input string tag, input string name, input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h", tag, name, act, exp);
        end
    endtask

    task automatic model_reset();
        m_conf = 0; m_shut = 0; m_base = 8'h00; m_stage = 4'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_strobe = 1'b0; bus_write = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus cycle: drive, compare against model, advance model at the edge
    task automatic step(input logic [23:0] a, input bit stb, input bit wr,
                        input logic [3:0] d, input string tag);
        bit         hit, idarea;
        logic [7:0] fb;
        logic [3:0] nib;
        logic [15:0] exp_rd;
        @(negedge clk);
        bus_addr = a; bus_strobe = stb; bus_write = wr; bus_wnib = d;
        #2;
        hit    = !m_conf && !m_shut && (a[23:16] == 8'hE8);
        idarea = (a[15:7] == 9'd0);
        fb     = ref_field(int'(a[6:2]));
        if (a[6:2] != 5'd0) fb = ~fb;
        nib    = a[1] ? fb[3:0] : fb[7:4];
        exp_rd = (hit && idarea) ? {nib, 12'h000} : 16'h0000;
        cmp(tag, "cfg_hit",    {15'd0, cfg_hit},    {15'd0, hit});
        cmp(tag, "rdata",      bus_rdata,           exp_rd);
        cmp(tag, "card_match", {15'd0, card_match}, {15'd0, m_conf && a[23:16] == m_base});
        cmp(tag, "configured", {15'd0, configured}, {15'd0, m_conf});
        cmp(tag, "shut_up",    {15'd0, shut_up},    {15'd0, m_shut});
        cmp(tag, "base_addr",  {8'd0, base_addr},   {8'd0, m_base});
        vectors++;
        @(posedge clk);
        if (stb && wr && hit && idarea) begin
            case (a[6:0])
                7'h4A: m_stage = d;
                7'h48: begin m_base = {d, m_stage}; m_conf = 1; end
                7'h4C: m_shut = 1;
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        // R1: state right after reset
        step(24'h000000, 0, 0, 4'h0, "R1");
        // R3 R4: sweep the whole identification area
        for (int off = 0; off < 128; off += 2)
            step(24'hE80000 + 24'(off), 1, 0, 4'h0, "R3_R4");
        // R2: outside the page and past the identification area
        step(24'hE90000, 1, 0, 4'h0, "R2");
        step(24'hE80100, 1, 0, 4'h0, "R2");
        // R10: ignored writes
        step(24'hE80048, 0, 1, 4'h9, "R10");
        step(24'hE80040, 1, 1, 4'h9, "R10");
        step(24'hE80049, 1, 1, 4'h9, "R10");
        step(24'hE80148, 1, 1, 4'h9, "R10");
        step(24'h200048, 1, 1, 4'h9, "R10");
        step(24'hE8004A, 1, 0, 4'h9, "R10");
        // R5: repeated staging, last wins
        step(24'hE8004A, 1, 1, 4'h3, "R5");
        step(24'hE8004A, 1, 1, 4'h7, "R5");
        // R6: commit, expect base 0xA7 next cycle
        step(24'hE80048, 1, 1, 4'hA, "R6");
        step(24'hE80000, 0, 0, 4'h0, "R6");
        // R7: configuration page gone, writes ignored
        step(24'hE80048, 1, 1, 4'h1, "R7");
        step(24'hE8004C, 1, 1, 4'h1, "R7");
        step(24'hE80000, 1, 0, 4'h0, "R7");
        // R8: decoder on the assigned page only
        step(24'hA70010, 1, 0, 4'h0, "R8");
        step(24'hA80000, 1, 0, 4'h0, "R8");
        step(24'hA6FFFE, 1, 0, 4'h0, "R8");
        // R11: commit without staging after reset
        do_reset();
        step(24'hE80048, 1, 1, 4'h5, "R11");
        step(24'h500000, 1, 0, 4'h0, "R11");
        // R9: shut-up then ignored commit
        do_reset();
        step(24'hE8004A, 1, 1, 4'hC, "R9");
        step(24'hE8004C, 1, 1, 4'h0, "R9");
        step(24'hE80048, 1, 1, 4'h4, "R9");
        step(24'hE80000, 1, 0, 4'h0, "R9");
        step(24'h4C0000, 1, 0, 4'h0, "R9");
        // R1: reset leaves the shut-up state
        do_reset();
        step(24'hE80000, 1, 0, 4'h0, "R1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule